// File: doc/BRIEF.md
# Posted-Write Bridge Buffer with Read Ordering

This block joins a downstream request bus, where several masters issue single-cycle requests, to an upstream bus that reaches memory. A write from downstream is taken into an eight-entry queue and acknowledged in the same cycle, long before it reaches the upstream side. Queued writes leave upstream one at a time, oldest first. Write latency is hidden, and write order is unchanged.

A read cannot be answered at once. The first attempt is told to retry, and the bridge records who asked and for which address in a single delayed-read slot. The read goes upstream only after every write accepted ahead of it has been handed over. Writes accepted after the read may stay queued behind it. The returned data is parked in the slot. Only the recorded master, repeating the same address, may take it. Every other read is told to retry while the slot is in use.

Top module: `posted_write_bridge`

## Requirements
- R1: After reset no upstream request is presented (upValid low), no downstream response is given, the write queue is empty and the delayed-read slot is free.
- R2: A downstream write (dnValid and dnWrite high) is acknowledged with dnAck in the same cycle whenever fewer than 8 writes are queued.
- R3: A downstream write that arrives while 8 writes are queued gets dnRetry, and it is not stored or forwarded.
- R4: Queued writes are presented upstream with upWrite high, in acceptance order and with their own address and data. A presented request stays unchanged until upReady is high.
- R5: A read is presented upstream with upWrite low and the recorded address. It is presented only after every write accepted before the read has completed its upstream handshake, and writes accepted later do not delay it.
- R6: A read that finds the slot free gets dnRetry, and its master number and address are recorded in the slot.
- R7: A cycle with upRespValid high while the slot's read is outstanding stores upRespData. The recording master's next read of the same address gets dnAck with that data on dnRdata, and the slot is freed.
- R8: While the slot is in use, a read from any other master, or from the same master to another address, gets dnRetry. In that cycle dnRdata is zero.
- R9: Each cycle with dnValid high gets exactly one of dnAck and dnRetry. A cycle with dnValid low gets neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dnValid | input | 1 | Downstream request present this cycle |
| dnWrite | input | 1 | 1 = write, 0 = read |
| dnMaster | input | MW (2) | Number of the requesting master |
| dnAddr | input | AW (32) | Request address |
| dnWdata | input | DW (32) | Write data |
| dnAck | output | 1 | Request completed this cycle |
| dnRetry | output | 1 | Request refused; repeat later |
| dnRdata | output | DW (32) | Read data, valid with dnAck on a read, zero otherwise |
| upValid | output | 1 | Upstream request presented |
| upWrite | output | 1 | Upstream request is a write |
| upAddr | output | AW (32) | Upstream address |
| upWdata | output | DW (32) | Upstream write data |
| upReady | input | 1 | Upstream accepts the presented request |
| upRespValid | input | 1 | Upstream read data returned |
| upRespData | input | DW (32) | Upstream read data |

## Verification
Constrained random traffic from four masters mixes writes and reads over a small address set. A bias replays the slot owner's own read, so completions happen often. Random gaps in upReady let the queue fill and drain at varying depths. Directed runs add three cases. The first posts writes both before and after a read while upstream stalls, which separates a correct barrier count from draining the whole queue or not waiting at all. The second has a foreign master, and the owner at a wrong address, try to take parked data, which separates a slot matched on master and address from one matched on address only. The third fills the queue to exactly 8, which catches an off-by-one full limit.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_BUSY = 2'd2,
    SLOT_DONE = 2'd3
  } slotState_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic slotLoad;
    logic dataLoad;
  } dpStrobe_t;
endpackage

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int MW    = 2,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [MW-1:0] dnMaster,
  input  logic [AW-1:0] dnAddr,
  input  logic [DW-1:0] dnWdata,
  input  logic [DW-1:0] upRespData,
  output logic [AW-1:0] headAddr,
  output logic [DW-1:0] headData,
  output logic [MW-1:0] slotMaster,
  output logic [AW-1:0] slotAddr,
  output logic [DW-1:0] slotData
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] addrMem [DEPTH];
  logic [DW-1:0] dataMem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrMem[wrPtr] <= dnAddr;
      dataMem[wrPtr] <= dnWdata;
    end
  end

  assign headAddr = addrMem[rdPtr];
  assign headData = dataMem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotMaster <= '0;
      slotAddr   <= '0;
      slotData   <= '0;
    end else begin
      if (strobe.slotLoad) begin
        slotMaster <= dnMaster;
        slotAddr   <= dnAddr;
      end
      if (strobe.dataLoad) slotData <= upRespData;
    end
  end
endmodule

// File: rtl/pwb_control.sv
module pwb_control
  import pwb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int MW    = 2,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dnValid,
  input  logic          dnWrite,
  input  logic [MW-1:0] dnMaster,
  input  logic [AW-1:0] dnAddr,
  input  logic [MW-1:0] slotMaster,
  input  logic [AW-1:0] slotAddr,
  input  logic          upReady,
  input  logic          upRespValid,
  output dpStrobe_t     strobe,
  output logic          dnAck,
  output logic          dnRetry,
  output logic          readGo,
  output logic          upValid,
  output logic [CW-1:0] fifoCount
);
  slotState_e    slotState;
  logic [CW-1:0] barrier;
  logic          fifoFull, ownerHit, collect;

  assign fifoFull = (fifoCount == CW'(DEPTH));
  assign ownerHit = (slotState == SLOT_DONE) && (dnMaster == slotMaster) &&
                    (dnAddr == slotAddr);
  assign readGo   = (slotState == SLOT_WAIT) && (barrier == '0);
  assign upValid  = readGo || (fifoCount != '0);

  always_comb begin
    strobe          = '0;
    strobe.push     = dnValid && dnWrite && !fifoFull;
    strobe.pop      = !readGo && (fifoCount != '0) && upReady;
    strobe.slotLoad = dnValid && !dnWrite && (slotState == SLOT_FREE);
    strobe.dataLoad = (slotState == SLOT_BUSY) && upRespValid;
  end

  assign collect = dnValid && !dnWrite && ownerHit;
  assign dnAck   = strobe.push || collect;
  assign dnRetry = dnValid && !dnAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoCount <= '0;
    end else begin
      fifoCount <= fifoCount + CW'(strobe.push) - CW'(strobe.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotState <= SLOT_FREE;
      barrier   <= '0;
    end else begin
      unique case (slotState)
        SLOT_FREE: if (strobe.slotLoad) begin
          slotState <= SLOT_WAIT;
          barrier   <= fifoCount - CW'(strobe.pop);
        end
        SLOT_WAIT: begin
          if (readGo && upReady) slotState <= SLOT_BUSY;
          else if (strobe.pop && barrier != '0) barrier <= barrier - 1'b1;
        end
        SLOT_BUSY: if (strobe.dataLoad) slotState <= SLOT_DONE;
        SLOT_DONE: if (collect) slotState <= SLOT_FREE;
        default:   slotState <= SLOT_FREE;
      endcase
    end
  end
endmodule

// File: rtl/posted_write_bridge.sv
module posted_write_bridge
  import pwb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int MW    = 2,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dnValid,
  input  logic          dnWrite,
  input  logic [MW-1:0] dnMaster,
  input  logic [AW-1:0] dnAddr,
  input  logic [DW-1:0] dnWdata,
  output logic          dnAck,
  output logic          dnRetry,
  output logic [DW-1:0] dnRdata,
  output logic          upValid,
  output logic          upWrite,
  output logic [AW-1:0] upAddr,
  output logic [DW-1:0] upWdata,
  input  logic          upReady,
  input  logic          upRespValid,
  input  logic [DW-1:0] upRespData
);
  localparam int CW = $clog2(DEPTH + 1);

  dpStrobe_t     strobe;
  logic          readGo;
  logic [CW-1:0] fifoCount;
  logic [AW-1:0] headAddr, slotAddr;
  logic [DW-1:0] headData, slotData;
  logic [MW-1:0] slotMaster;

  pwb_control #(.AW(AW), .MW(MW), .DEPTH(DEPTH), .CW(CW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .dnValid(dnValid), .dnWrite(dnWrite), .dnMaster(dnMaster), .dnAddr(dnAddr),
    .slotMaster(slotMaster), .slotAddr(slotAddr),
    .upReady(upReady), .upRespValid(upRespValid),
    .strobe(strobe), .dnAck(dnAck), .dnRetry(dnRetry),
    .readGo(readGo), .upValid(upValid), .fifoCount(fifoCount)
  );

  pwb_datapath #(.AW(AW), .DW(DW), .MW(MW), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dnMaster(dnMaster), .dnAddr(dnAddr), .dnWdata(dnWdata),
    .upRespData(upRespData),
    .headAddr(headAddr), .headData(headData),
    .slotMaster(slotMaster), .slotAddr(slotAddr), .slotData(slotData)
  );

  assign upWrite = !readGo;
  assign upAddr  = readGo ? slotAddr : headAddr;
  assign upWdata = readGo ? '0 : headData;
  assign dnRdata = (dnAck && !dnWrite) ? slotData : '0;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          dnValid,
  input logic          dnWrite,
  input logic          dnAck,
  input logic          dnRetry,
  input logic [DW-1:0] dnRdata,
  input logic          upValid,
  input logic          upReady,
  input logic          upWrite,
  input logic [AW-1:0] upAddr,
  input logic [DW-1:0] upWdata,
  input logic [CW-1:0] fifoCount
);
  a_r9_one_response: assert property (@(posedge clk) disable iff (!rstN)
    dnValid |-> $countones({dnAck, dnRetry}) == 1);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !dnValid |-> !dnAck && !dnRetry);

  a_r3_full_retry: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && dnWrite && fifoCount == CW'(DEPTH)) |-> dnRetry);

  a_r8_no_stray_data: assert property (@(posedge clk) disable iff (!rstN)
    dnRetry |-> dnRdata == '0);

  a_r4_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && !upReady) |=> upValid && $stable(upWrite) && $stable(upAddr) &&
                              $stable(upWdata));

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CW'(DEPTH));
endmodule

bind posted_write_bridge pwb_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rstN(rstN), .dnValid(dnValid), .dnWrite(dnWrite),
  .dnAck(dnAck), .dnRetry(dnRetry), .dnRdata(dnRdata),
  .upValid(upValid), .upReady(upReady), .upWrite(upWrite),
  .upAddr(upAddr), .upWdata(upWdata), .fifoCount(fifoCount)
);

// File: tb/posted_write_bridge_tb.sv
`timescale 1ns/1ps
module posted_write_bridge_tb_top;
  localparam int AW = 32, DW = 32, MW = 2, DEPTH = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          dnValid = 1'b0, dnWrite = 1'b0;
  logic [MW-1:0] dnMaster = '0;
  logic [AW-1:0] dnAddr = '0;
  logic [DW-1:0] dnWdata = '0;
  logic          dnAck, dnRetry;
  logic [DW-1:0] dnRdata;
  logic          upValid, upWrite;
  logic [AW-1:0] upAddr;
  logic [DW-1:0] upWdata;
  logic          upReady = 1'b0, upRespValid = 1'b0;
  logic [DW-1:0] upRespData = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // bench model
  logic [63:0]   mQ[$];
  int            mSt = 0;
  logic [MW-1:0] mSlotM = '0;
  logic [AW-1:0] mSlotA = '0;
  logic [DW-1:0] mSlotD = '0;
  int            mBar = 0;

  always #2.5 clk = ~clk;

  posted_write_bridge #(.AW(AW), .DW(DW), .MW(MW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN),
    .dnValid(dnValid), .dnWrite(dnWrite), .dnMaster(dnMaster), .dnAddr(dnAddr),
    .dnWdata(dnWdata), .dnAck(dnAck), .dnRetry(dnRetry), .dnRdata(dnRdata),
    .upValid(upValid), .upWrite(upWrite), .upAddr(upAddr), .upWdata(upWdata),
    .upReady(upReady), .upRespValid(upRespValid), .upRespData(upRespData)
  );

  function automatic logic [DW-1:0] memFn(input logic [AW-1:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit v, input bit w, input logic [MW-1:0] m,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit rdy, input bit rv);
    bit readGoE, expUpV, popE, issueE, hitE;
    int sizeBefore, oldSt;
    @(negedge clk);
    dnValid = v; dnWrite = w; dnMaster = m; dnAddr = a; dnWdata = d;
    upReady = rdy; upRespValid = rv; upRespData = memFn(mSlotA);
    #1;
    sizeBefore = mQ.size();
    oldSt = mSt;
    readGoE = (mSt == 1) && (mBar == 0);
    expUpV = readGoE || (sizeBefore != 0);
    check(upValid == expUpV, readGoE ? "R5 upValid" : "R4 upValid",
          64'(upValid), 64'(expUpV));
    if (expUpV && upValid) begin
      if (readGoE)
        check(!upWrite && upAddr == mSlotA, "R5 read presented",
              {31'(0), upWrite, upAddr}, {32'd0, mSlotA});
      else
        check(upWrite && upAddr == mQ[0][63:32] && upWdata == mQ[0][31:0],
              "R4 write order", {upAddr, upWdata}, mQ[0]);
    end
    popE = expUpV && !readGoE && rdy;
    issueE = readGoE && rdy;
    hitE = (mSt == 3) && (m == mSlotM) && (a == mSlotA);
    if (!v) begin
      check(!dnAck && !dnRetry, "R9 idle", {dnAck, dnRetry}, 64'd0);
    end else if (w) begin
      if (sizeBefore < DEPTH) check(dnAck && !dnRetry, "R2 write posted",
                                    {dnAck, dnRetry}, 64'd2);
      else check(!dnAck && dnRetry, "R3 full retry", {dnAck, dnRetry}, 64'd1);
    end else if (hitE) begin
      check(dnAck && !dnRetry && dnRdata == mSlotD, "R7 owner collect",
            {dnAck, dnRetry, dnRdata}, {2'b10, mSlotD});
    end else begin
      check(!dnAck && dnRetry && dnRdata == '0, (mSt == 0) ? "R6 first read" : "R8 foreign read",
            {dnAck, dnRetry, dnRdata}, {2'b01, 32'd0});
    end
    if (popE) begin
      void'(mQ.pop_front());
      if (oldSt == 1 && mBar != 0) mBar--;
    end
    case (oldSt)
      0: if (v && !w) begin mSt = 1; mSlotM = m; mSlotA = a; mBar = mQ.size(); end
      1: if (issueE) mSt = 2;
      2: if (rv) begin mSt = 3; mSlotD = memFn(mSlotA); end
      3: if (v && !w && hitE) mSt = 0;
      default: ;
    endcase
    if (v && w && sizeBefore < DEPTH) mQ.push_back({a, d});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd20240611);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check(!upValid && !dnAck && !dnRetry, "R1 reset", {upValid, dnAck, dnRetry}, 64'd0);

    // R5: writes before and after a read, upstream stalled
    for (int i = 0; i < 3; i++) cycle(1, 1, 2'd0, 32'h100 + 32'(i * 4), 32'hA0 + 32'(i), 0, 0);
    cycle(1, 0, 2'd1, 32'h40, 0, 0, 0);   // R6 retry, slot loaded
    for (int i = 0; i < 2; i++) cycle(1, 1, 2'd2, 32'h200 + 32'(i * 4), 32'hB0 + 32'(i), 0, 0);
    for (int i = 0; i < 5; i++) cycle(0, 0, 0, 0, 0, 1, 0);
    // R8: foreign master and wrong address while slot busy / done
    cycle(1, 0, 2'd2, 32'h40, 0, 1, 0);
    cycle(0, 0, 0, 0, 0, 1, 1);           // R7 data returns
    cycle(1, 0, 2'd2, 32'h40, 0, 1, 0);   // R8 other master, same address
    cycle(1, 0, 2'd1, 32'h44, 0, 1, 0);   // R8 owner, other address
    cycle(1, 0, 2'd1, 32'h40, 0, 1, 0);   // R7 owner collects
    cycle(1, 0, 2'd3, 32'h48, 0, 1, 0);   // R6 slot free again
    // R3: fill to exactly DEPTH
    for (int i = 0; i < DEPTH + 2; i++) cycle(1, 1, 2'd3, 32'h300 + 32'(i * 4), 32'hC0 + 32'(i), 0, 0);
    for (int i = 0; i < 12; i++) cycle(0, 0, 0, 0, 0, 1, 1);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit v, w, rdy, rv;
      logic [MW-1:0] m;
      logic [AW-1:0] a;
      v = ($urandom % 3) != 0;
      w = $urandom % 2;
      m = MW'($urandom % 4);
      a = 32'(($urandom % 6) * 4);
      if (mSt == 3 && ($urandom % 2) == 1) begin w = 0; m = mSlotM; a = mSlotA; end
      rdy = ((n % 400) < 30) ? 1'b0 : (($urandom % 4) != 0);
      rv = ($urandom % 3) == 0;
      cycle(v, w, m, a, $urandom, rdy, rv);
    end
    for (int i = 0; i < 20; i++) cycle(0, 0, 0, 0, 0, 1, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule